// File: doc/BRIEF.md
# Dual-Channel Subchannel Service Sequencer

This block moves data from device controllers into memory on behalf of a set of subchannels. Two channels, each with its own bank of subchannels, run side by side and share a single word-wide memory write port. Every subchannel keeps three control values in a small register file: a byte address, a remaining byte count and a done mark. Each stored entry carries a parity bit. Software loads an entry through a configuration write port. A device then asks for service by naming its subchannel, and the channel moves its bytes to memory at the stored address.

A narrow device moves one byte per service connection. A wide device moves up to four bytes per connection, clipped to the end of the current memory word and to the remaining count. A wide device may also ask for a burst. It then stays connected and moves one word-aligned group per memory beat. The burst ends when the count reaches zero or when the device flags the end of its transfer.

Byte addresses advance by the number of bytes moved. Each channel's memory requests go through a round-robin arbiter. When an entry's count reaches zero, the channel pulses a completion interrupt that carries the subchannel number. When a read of an entry finds a parity mismatch, the channel raises a fault flag that stays set.

Top module: `io_chan_seq`

## Requirements
- R1: A narrow connection (wide=0) writes exactly one byte. The write goes to memory word address[ADDR_W-1:2], with a single byte-enable bit at lane address[1:0]. The data is dev_data[7:0] placed at bits 8*lane. The stored address then advances by 1 and the stored count drops by 1.
- R2: A wide connection without burst writes n = min(4 - address[1:0], count) bytes. It uses byte enables ((1<<n)-1) << address[1:0], and its data is dev_data shifted left by 8*address[1:0]. Address and count then move by n.
- R3: A wide burst connection (wide=1, burst=1) keeps dev_req high and gets one dev_ack per memory beat. It ends after the beat that brings the count to zero or after the beat presented with dev_end=1. An entry ended by dev_end keeps its advanced address and nonzero count for the next connection.
- R4: The memory port grants at most one channel per cycle. When both channels request, a channel granted in one cycle is not selected in the next.
- R5: Channels 0 and 1 hold separate register files, so a subchannel number used on one channel leaves the same number on the other untouched.
- R6: A configuration write with cfg_par_flip=1 stores a wrong parity bit. The next connection to that entry gets a dev_ack, makes no memory write and sets par_fault for that channel. par_fault stays high until reset.
- R7: The beat that brings a count to zero pulses done_irq for one cycle, in the same cycle as its dev_ack, with done_sub holding the subchannel number. A burst ended by dev_end with a nonzero count raises no done_irq.
- R8: A connection to an entry whose count is zero, or whose done mark is set, gets a dev_ack and makes no memory write.
- R9: While reset is held, mem_req, dev_ack, done_irq and par_fault are all low.
- R10: While a channel's request waits for mem_gnt, that channel's memory address and byte enables stay unchanged. No dev_ack is given until the grant.
- R11: A connection naming a subchannel at or above the channel's subchannel count gets a dev_ack and makes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one subchannel entry. It is dropped if that channel writes back in the same cycle |
| cfg_chan | input | 1 | Channel of the entry being loaded |
| cfg_sub | input | SUB_W | Subchannel of the entry being loaded |
| cfg_addr | input | ADDR_W | Starting byte address |
| cfg_count | input | CNT_W | Byte count; loading also clears the done mark |
| cfg_par_flip | input | 1 | Store inverted parity (fault injection) |
| dev_req | input | 2 | Per channel: service request, held until dev_ack |
| dev_sub | input | 2 x SUB_W | Per channel: requesting subchannel |
| dev_wide | input | 2 | Per channel: device moves up to four bytes per connection |
| dev_burst | input | 2 | Per channel: stay connected (only with dev_wide) |
| dev_end | input | 2 | Per channel: current beat is the last of the transfer |
| dev_data | input | 2 x 32 | Per channel: connection bytes, first byte in bits 7:0 |
| dev_ack | output | 2 | Per channel: one-cycle acknowledge of a beat or refused connection |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| par_fault | output | 2 | Per channel: sticky parity fault flag |
| done_irq | output | 2 | Per channel: one-cycle completion interrupt |
| done_sub | output | 2 x SUB_W | Per channel: subchannel that completed |

## Verification
Some properties are checked on every cycle:
- Only one channel holds the memory port at a time.
- When both channels request, grants alternate.
- A narrow request always carries a single byte enable.
- A waiting request keeps its address and enables.
- The parity fault flag never clears.
- A completion pulse always follows a granted beat.

The directed scenarios show what those properties cannot:
- the exact memory words, lanes and data of each connection;
- that burst and end-of-transfer state is saved per subchannel;
- that the two channels' register files are independent;
- that faulted, empty and out-of-range connections are refused with no memory write.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic {ST_IDLE, ST_XFER} eng_state_t;

  // number of bytes one beat moves: clipped to the word end and the count
  function automatic logic [2:0] beat_len(input logic wide, input logic [1:0] off,
                                          input logic [31:0] cnt);
    logic [2:0] room;
    room = 3'd4 - {1'b0, off};
    if (!wide) return 3'd1;
    if (cnt < 32'(room)) return cnt[2:0];
    return room;
  endfunction

  function automatic logic [3:0] beat_mask(input logic [2:0] n, input logic [1:0] off);
    logic [3:0] base;
    base = 4'((5'd1 << n) - 5'd1);
    return base << off;
  endfunction

  function automatic logic [WORD_W-1:0] lane_place(input logic [WORD_W-1:0] d,
                                                   input logic [1:0] off);
    return d << (8 * off);
  endfunction

endpackage

// File: rtl/io_sub_regfile.sv
module io_sub_regfile #(
  parameter int NSUB   = 8,
  parameter int SUB_W  = 5,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  rd_sub,
  output logic              rd_valid,
  output logic              rd_par_ok,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              rd_done,
  input  logic              eng_we,
  input  logic [SUB_W-1:0]  eng_sub,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [CNT_W-1:0]  eng_cnt,
  input  logic              eng_done,
  input  logic              cfg_we,
  input  logic [SUB_W-1:0]  cfg_sub,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_flip
);

  localparam int IDX_W = (NSUB > 1) ? $clog2(NSUB) : 1;
  localparam int ENT_W = ADDR_W + CNT_W + 2;

  logic [ENT_W-1:0] store [0:NSUB-1];
  logic [ENT_W-1:0] rd_word;
  logic [IDX_W-1:0] rd_idx;

  function automatic logic [ENT_W-1:0] pack_entry(input logic [ADDR_W-1:0] a,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic d, input logic flip);
    logic p;
    p = (^{d, a, c}) ^ flip;
    return {p, d, a, c};
  endfunction

  assign rd_valid  = 32'(rd_sub) < NSUB;
  assign rd_idx    = rd_valid ? rd_sub[IDX_W-1:0] : '0;
  assign rd_word   = store[rd_idx];
  assign rd_par_ok = ~(^rd_word);
  assign rd_cnt    = rd_word[CNT_W-1:0];
  assign rd_addr   = rd_word[CNT_W +: ADDR_W];
  assign rd_done   = rd_word[ENT_W-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSUB; i++) store[i] <= '0;
    end else if (eng_we) begin
      if (32'(eng_sub) < NSUB)
        store[eng_sub[IDX_W-1:0]] <= pack_entry(eng_addr, eng_cnt, eng_done, 1'b0);
    end else if (cfg_we) begin
      if (32'(cfg_sub) < NSUB)
        store[cfg_sub[IDX_W-1:0]] <= pack_entry(cfg_addr, cfg_cnt, 1'b0, cfg_flip);
    end
  end

endmodule

// File: rtl/io_chan_engine.sv
module io_chan_engine
  import io_seq_pkg::*;
#(
  parameter int SUB_W  = 5,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_req,
  input  logic [SUB_W-1:0]  dev_sub,
  input  logic              dev_wide,
  input  logic              dev_burst,
  input  logic              dev_end,
  input  logic [WORD_W-1:0] dev_data,
  output logic              dev_ack,
  output logic [SUB_W-1:0]  rd_sub,
  input  logic              rd_valid,
  input  logic              rd_par_ok,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic              rd_done,
  output logic              wb_en,
  output logic [SUB_W-1:0]  wb_sub,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [CNT_W-1:0]  wb_cnt,
  output logic              wb_done,
  output logic              chan_req,
  output logic [ADDR_W-3:0] chan_addr,
  output logic [WORD_W-1:0] chan_wdata,
  output logic [3:0]        chan_be,
  input  logic              chan_gnt,
  output logic              cur_wide_o,
  output logic              par_fault,
  output logic              done_irq,
  output logic [SUB_W-1:0]  done_sub
);

  eng_state_t        st;
  logic [SUB_W-1:0]  cur_sub;
  logic              cur_wide, cur_burst;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;

  logic [2:0]        n_bytes;
  logic [CNT_W-1:0]  cnt_next;
  logic              beat_done, beat_last, entry_empty;

  assign rd_sub      = dev_sub;
  assign entry_empty = rd_done || (rd_cnt == '0);
  assign n_bytes     = beat_len(cur_wide, cur_addr[1:0], 32'(cur_cnt));
  assign cnt_next    = cur_cnt - CNT_W'(n_bytes);
  assign beat_last   = (cnt_next == '0) || dev_end || !cur_burst;

  assign chan_req    = (st == ST_XFER) && dev_req;
  assign chan_addr   = cur_addr[ADDR_W-1:2];
  assign chan_be     = beat_mask(n_bytes, cur_addr[1:0]);
  assign chan_wdata  = lane_place(dev_data, cur_addr[1:0]);
  assign beat_done   = chan_req && chan_gnt;
  assign cur_wide_o  = cur_wide;

  assign wb_en   = beat_done;
  assign wb_sub  = cur_sub;
  assign wb_addr = cur_addr + ADDR_W'(n_bytes);
  assign wb_cnt  = cnt_next;
  assign wb_done = (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_sub   <= '0;
      cur_wide  <= 1'b0;
      cur_burst <= 1'b0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      dev_ack   <= 1'b0;
      par_fault <= 1'b0;
      done_irq  <= 1'b0;
      done_sub  <= '0;
    end else begin
      dev_ack  <= 1'b0;
      done_irq <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (dev_req) begin
            if (!rd_valid) begin
              dev_ack <= 1'b1;
            end else if (!rd_par_ok) begin
              dev_ack   <= 1'b1;
              par_fault <= 1'b1;
            end else if (entry_empty) begin
              dev_ack <= 1'b1;
            end else begin
              cur_sub   <= dev_sub;
              cur_wide  <= dev_wide;
              cur_burst <= dev_burst && dev_wide;
              cur_addr  <= rd_addr;
              cur_cnt   <= rd_cnt;
              st        <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (!dev_req) begin
            st <= ST_IDLE;
          end else if (beat_done) begin
            cur_addr <= wb_addr;
            cur_cnt  <= cnt_next;
            dev_ack  <= 1'b1;
            if (cnt_next == '0) begin
              done_irq <= 1'b1;
              done_sub <= cur_sub;
            end
            if (beat_last) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/io_mem_arb.sv
module io_mem_arb
  import io_seq_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            req,
  input  logic [1:0][MA_W-1:0]  addr,
  input  logic [1:0][WORD_W-1:0] wdata,
  input  logic [1:0][3:0]       be,
  output logic [1:0]            gnt,
  output logic                  sel,
  output logic                  mem_req,
  output logic [MA_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  output logic [3:0]            mem_be,
  input  logic                  mem_gnt
);

  logic prio;

  assign sel       = (req == 2'b11) ? prio : req[1];
  assign mem_req   = |req;
  assign mem_addr  = addr[sel];
  assign mem_wdata = wdata[sel];
  assign mem_be    = be[sel];

  generate
    for (genvar c = 0; c < 2; c++) begin : g_gnt
      assign gnt[c] = mem_gnt && req[c] && (sel == 1'(c));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prio <= 1'b0;
    else if (mem_req && mem_gnt) prio <= ~sel;
  end

endmodule

// File: rtl/io_chan_seq.sv
module io_chan_seq
  import io_seq_pkg::*;
#(
  parameter int NSUB_A = 8,
  parameter int NSUB_B = 8,
  parameter int SUB_W  = 5,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_chan,
  input  logic [SUB_W-1:0]        cfg_sub,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [CNT_W-1:0]        cfg_count,
  input  logic                    cfg_par_flip,
  input  logic [1:0]              dev_req,
  input  logic [1:0][SUB_W-1:0]   dev_sub,
  input  logic [1:0]              dev_wide,
  input  logic [1:0]              dev_burst,
  input  logic [1:0]              dev_end,
  input  logic [1:0][31:0]        dev_data,
  output logic [1:0]              dev_ack,
  output logic                    mem_req,
  output logic [ADDR_W-3:0]       mem_addr,
  output logic [31:0]             mem_wdata,
  output logic [3:0]              mem_be,
  input  logic                    mem_gnt,
  output logic [1:0]              par_fault,
  output logic [1:0]              done_irq,
  output logic [1:0][SUB_W-1:0]   done_sub
);

  localparam int MA_W = ADDR_W - 2;

  logic [1:0]              chan_req, chan_gnt, cur_wide;
  logic [1:0][MA_W-1:0]    chan_addr;
  logic [1:0][WORD_W-1:0]  chan_wdata;
  logic [1:0][3:0]         chan_be;
  logic                    mem_sel;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_ch
      localparam int NS = (g == 0) ? NSUB_A : NSUB_B;

      logic [SUB_W-1:0]  rd_sub, wb_sub;
      logic              rd_valid, rd_par_ok, rd_done, wb_en, wb_done;
      logic [ADDR_W-1:0] rd_addr, wb_addr;
      logic [CNT_W-1:0]  rd_cnt, wb_cnt;

      io_sub_regfile #(.NSUB(NS), .SUB_W(SUB_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_sub(rd_sub), .rd_valid(rd_valid), .rd_par_ok(rd_par_ok),
        .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_done(rd_done),
        .eng_we(wb_en), .eng_sub(wb_sub), .eng_addr(wb_addr), .eng_cnt(wb_cnt),
        .eng_done(wb_done),
        .cfg_we(cfg_we && (cfg_chan == 1'(g))), .cfg_sub(cfg_sub), .cfg_addr(cfg_addr),
        .cfg_cnt(cfg_count), .cfg_flip(cfg_par_flip)
      );

      io_chan_engine #(.SUB_W(SUB_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .dev_req(dev_req[g]), .dev_sub(dev_sub[g]), .dev_wide(dev_wide[g]),
        .dev_burst(dev_burst[g]), .dev_end(dev_end[g]), .dev_data(dev_data[g]),
        .dev_ack(dev_ack[g]),
        .rd_sub(rd_sub), .rd_valid(rd_valid), .rd_par_ok(rd_par_ok),
        .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_done(rd_done),
        .wb_en(wb_en), .wb_sub(wb_sub), .wb_addr(wb_addr), .wb_cnt(wb_cnt),
        .wb_done(wb_done),
        .chan_req(chan_req[g]), .chan_addr(chan_addr[g]), .chan_wdata(chan_wdata[g]),
        .chan_be(chan_be[g]), .chan_gnt(chan_gnt[g]), .cur_wide_o(cur_wide[g]),
        .par_fault(par_fault[g]), .done_irq(done_irq[g]), .done_sub(done_sub[g])
      );
    end
  endgenerate

  io_mem_arb #(.MA_W(MA_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(chan_req), .addr(chan_addr), .wdata(chan_wdata), .be(chan_be),
    .gnt(chan_gnt), .sel(mem_sel),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_gnt(mem_gnt)
  );

endmodule

// File: rtl/io_chan_seq_chk.sv
module io_chan_seq_chk #(
  parameter int MA_W = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           chan_req,
  input logic [1:0]           chan_gnt,
  input logic                 mem_sel,
  input logic [1:0][MA_W-1:0] chan_addr,
  input logic [1:0][3:0]      chan_be,
  input logic [1:0]           cur_wide,
  input logic [1:0]           par_fault,
  input logic [1:0]           done_irq,
  input logic [1:0]           dev_ack,
  input logic                 mem_req
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!mem_req && dev_ack == 2'b00 && done_irq == 2'b00);
    end
  end

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chk
      assert_round_robin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_gnt[c]) && chan_req == 2'b11) |-> (mem_sel != 1'(c)));

      assert_narrow_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req[c] && !cur_wide[c]) |-> ($countones(chan_be[c]) == 1));

      assert_wide_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chan_req[c] |-> (chan_be[c] != 4'b0000));

      assert_wait_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req[c] && !chan_gnt[c]) |=>
          (!chan_req[c] || ($stable(chan_addr[c]) && $stable(chan_be[c]) && !dev_ack[c])));

      assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(par_fault[c]) |-> par_fault[c]);

      assert_irq_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq[c] |-> ($past(chan_gnt[c]) && dev_ack[c]));
    end
  endgenerate

endmodule

bind io_chan_seq io_chan_seq_chk #(.MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_gnt(chan_gnt),
  .mem_sel(mem_sel), .chan_addr(chan_addr), .chan_be(chan_be), .cur_wide(cur_wide),
  .par_fault(par_fault), .done_irq(done_irq), .dev_ack(dev_ack), .mem_req(mem_req)
);

// File: tb/io_chan_seq_test.sv
module io_chan_seq_test;

  localparam int SUB_W = 5;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic              cfg_we = 0, cfg_chan = 0, cfg_par_flip = 0;
  logic [SUB_W-1:0]  cfg_sub = '0;
  logic [15:0]       cfg_addr = '0, cfg_count = '0;
  logic              r_req [2], r_wide [2], r_burst [2], r_end [2];
  logic [SUB_W-1:0]  r_sub [2];
  logic [31:0]       r_data [2];
  logic [1:0]              dev_req, dev_wide, dev_burst, dev_end, dev_ack;
  logic [1:0][SUB_W-1:0]   dev_sub, done_sub;
  logic [1:0][31:0]        dev_data;
  logic              mem_req, mem_gnt;
  logic [13:0]       mem_addr;
  logic [31:0]       mem_wdata;
  logic [3:0]        mem_be;
  logic [1:0]        par_fault, done_irq;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      dev_req[c] = r_req[c]; dev_wide[c] = r_wide[c]; dev_burst[c] = r_burst[c];
      dev_end[c] = r_end[c]; dev_sub[c] = r_sub[c]; dev_data[c] = r_data[c];
    end
  end
  assign mem_gnt = gnt_en;
  logic gnt_en = 1;

  io_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sub(cfg_sub),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_par_flip(cfg_par_flip),
    .dev_req(dev_req), .dev_sub(dev_sub), .dev_wide(dev_wide), .dev_burst(dev_burst),
    .dev_end(dev_end), .dev_data(dev_data), .dev_ack(dev_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_gnt(mem_gnt), .par_fault(par_fault), .done_irq(done_irq), .done_sub(done_sub)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [13:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [3:0]  lg_be [64];
  int lg_n = 0;
  int ack_cnt [2] = '{0, 0};
  int irq_cnt [2] = '{0, 0};
  int irq_sub [2] = '{0, 0};

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt && lg_n < 64) begin
      lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_wdata; lg_be[lg_n] = mem_be;
      lg_n = lg_n + 1;
    end
    for (int c = 0; c < 2; c++) begin
      if (dev_ack[c]) ack_cnt[c] = ack_cnt[c] + 1;
      if (done_irq[c]) begin irq_cnt[c] = irq_cnt[c] + 1; irq_sub[c] = int'(done_sub[c]); end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk_log(input int idx, input logic [13:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string tag);
    if (idx >= lg_n) begin
      chk(0, tag, "missing write", lg_n, idx + 1);
      return;
    end
    chk(lg_addr[idx] == a, tag, "word address", lg_addr[idx], a);
    chk(lg_be[idx] == be, tag, "byte enables", lg_be[idx], be);
    chk((lg_data[idx] & be_bits(be)) == (d & be_bits(be)), tag, "data",
        lg_data[idx] & be_bits(be), d & be_bits(be));
  endtask

  task automatic cfg(input int ch, input int sub, input logic [15:0] a,
                     input logic [15:0] n, input bit flip);
    @(posedge clk); #1;
    cfg_we = 1; cfg_chan = 1'(ch); cfg_sub = SUB_W'(sub); cfg_addr = a; cfg_count = n;
    cfg_par_flip = flip;
    @(posedge clk); #1;
    cfg_we = 0; cfg_par_flip = 0;
  endtask

  task automatic conn(input int ch, input int sub, input bit wide, input bit burst,
                      input int nbeats, input int end_at, input logic [31:0] base);
    int beat = 0;
    int wd = 0;
    @(posedge clk); #1;
    r_req[ch] = 1; r_sub[ch] = SUB_W'(sub); r_wide[ch] = wide; r_burst[ch] = burst;
    r_data[ch] = base; r_end[ch] = (end_at == 0);
    while (beat < nbeats && wd < 100) begin
      @(posedge clk); #1;
      wd++;
      if (dev_ack[ch]) begin
        beat++;
        r_data[ch] = base + 32'(beat);
        r_end[ch] = (beat == end_at);
      end
    end
    r_req[ch] = 0; r_end[ch] = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_req == 0, "R9", "mem_req in reset", mem_req, 0);
    chk(dev_ack == 0 && done_irq == 0, "R9", "ack/irq in reset", {dev_ack, done_irq}, 0);
    chk(par_fault == 0, "R9", "par_fault in reset", par_fault, 0);
  endtask

  task automatic t_narrow();
    int b = lg_n;
    cfg(0, 1, 16'h0102, 16'd3, 0);
    conn(0, 1, 0, 0, 1, -1, 32'h000000AB);
    conn(0, 1, 0, 0, 1, -1, 32'h000000CD);
    settle();
    chk(irq_cnt[0] == 0, "R7", "no irq before count zero", irq_cnt[0], 0);
    conn(0, 1, 0, 0, 1, -1, 32'h000000EF);
    settle();
    chk_log(b,     14'h040, 4'b0100, 32'h00AB0000, "R1");
    chk_log(b + 1, 14'h040, 4'b1000, 32'hCD000000, "R1");
    chk_log(b + 2, 14'h041, 4'b0001, 32'h000000EF, "R1");
    chk(irq_cnt[0] == 1 && irq_sub[0] == 1, "R7", "completion irq sub", irq_sub[0], 1);
  endtask

  task automatic t_wide();
    int b = lg_n;
    cfg(1, 2, 16'h0201, 16'd10, 0);
    conn(1, 2, 1, 0, 1, -1, 32'h44332211);
    conn(1, 2, 1, 0, 1, -1, 32'h88776655);
    conn(1, 2, 1, 0, 1, -1, 32'hCCBBAA99);
    settle();
    chk(lg_n == b + 3, "R2", "write count", lg_n - b, 3);
    chk_log(b,     14'h080, 4'b1110, 32'h33221100, "R2");
    chk_log(b + 1, 14'h081, 4'b1111, 32'h88776655, "R2");
    chk_log(b + 2, 14'h082, 4'b0111, 32'h00BBAA99, "R2");
    chk(irq_cnt[1] == 1 && irq_sub[1] == 2, "R7", "channel 1 irq sub", irq_sub[1], 2);
  endtask

  task automatic t_burst();
    int b = lg_n;
    int a0 = ack_cnt[0];
    int i0 = irq_cnt[0];
    cfg(0, 5, 16'h0300, 16'd9, 0);
    conn(0, 5, 1, 1, 3, -1, 32'h10203040);
    settle();
    chk(ack_cnt[0] - a0 == 3, "R3", "burst beats acked", ack_cnt[0] - a0, 3);
    chk(lg_n == b + 3, "R3", "burst write count", lg_n - b, 3);
    chk_log(b,     14'h0C0, 4'b1111, 32'h10203040, "R3");
    chk_log(b + 1, 14'h0C1, 4'b1111, 32'h10203041, "R3");
    chk_log(b + 2, 14'h0C2, 4'b0001, 32'h10203042, "R3");
    chk(irq_cnt[0] == i0 + 1 && irq_sub[0] == 5, "R7", "burst completion", irq_sub[0], 5);
  endtask

  task automatic t_burst_end();
    int b = lg_n;
    int i0 = irq_cnt[0];
    cfg(0, 6, 16'h0400, 16'd20, 0);
    conn(0, 6, 1, 1, 2, 1, 32'hA0A0A0A0);
    settle();
    chk(lg_n == b + 2, "R3", "end-of-transfer stops burst", lg_n - b, 2);
    chk_log(b + 1, 14'h101, 4'b1111, 32'hA0A0A0A1, "R3");
    chk(irq_cnt[0] == i0, "R7", "no irq on device end", irq_cnt[0], i0);
    conn(0, 6, 0, 0, 1, -1, 32'h0000005A);
    settle();
    chk_log(b + 2, 14'h102, 4'b0001, 32'h0000005A, "R3");
  endtask

  task automatic t_parity();
    int b = lg_n;
    int a0 = ack_cnt[0];
    cfg(0, 7, 16'h0000, 16'd4, 1);
    conn(0, 7, 0, 0, 1, -1, 32'h11);
    settle();
    chk(ack_cnt[0] == a0 + 1, "R6", "faulted connection acked", ack_cnt[0] - a0, 1);
    chk(lg_n == b, "R6", "no write on parity fault", lg_n - b, 0);
    chk(par_fault == 2'b01, "R6", "fault flag", par_fault, 2'b01);
  endtask

  task automatic t_refused();
    int b = lg_n;
    int a1 = ack_cnt[1];
    cfg(1, 4, 16'h0700, 16'd0, 0);
    conn(1, 4, 0, 0, 1, -1, 32'h22);
    conn(1, 2, 0, 0, 1, -1, 32'h23);
    conn(1, 9, 0, 0, 1, -1, 32'h24);
    settle();
    chk(ack_cnt[1] == a1 + 3, "R8", "refused connections acked", ack_cnt[1] - a1, 3);
    chk(lg_n == b, "R8", "no write for empty or done entry", lg_n - b, 0);
    chk(lg_n == b, "R11", "no write for out-of-range subchannel", lg_n - b, 0);
  endtask

  task automatic t_arb();
    int b = lg_n;
    cfg(0, 0, 16'h0500, 16'd8, 0);
    cfg(1, 0, 16'h0600, 16'd8, 0);
    fork
      conn(0, 0, 1, 1, 2, -1, 32'h01010101);
      conn(1, 0, 1, 1, 2, -1, 32'h02020202);
    join
    settle();
    chk(lg_n == b + 4, "R4", "interleaved write count", lg_n - b, 4);
    for (int i = b; i < b + 3 && i + 1 < lg_n; i++)
      chk((lg_addr[i] >= 14'h180) != (lg_addr[i + 1] >= 14'h180), "R4",
          "grants alternate", lg_addr[i + 1], lg_addr[i]);
    begin
      int na = 0;
      int nb = 0;
      for (int i = b; i < lg_n; i++) begin
        if (lg_addr[i] >= 14'h180) begin
          chk(lg_addr[i] == 14'(14'h180 + nb), "R5", "channel 1 address", lg_addr[i], 14'h180 + nb);
          nb++;
        end else begin
          chk(lg_addr[i] == 14'(14'h140 + na), "R5", "channel 0 address", lg_addr[i], 14'h140 + na);
          na++;
        end
      end
    end
  endtask

  task automatic t_stall();
    int b = lg_n;
    int a1 = ack_cnt[1];
    cfg(1, 5, 16'h0800, 16'd2, 0);
    gnt_en = 0;
    fork
      conn(1, 5, 0, 0, 1, -1, 32'h77);
      begin
        repeat (6) @(negedge clk);
        chk(mem_req == 1 && mem_addr == 14'h200, "R10", "request held", mem_addr, 14'h200);
        chk(ack_cnt[1] == a1, "R10", "no ack before grant", ack_cnt[1] - a1, 0);
        gnt_en = 1;
      end
    join
    settle();
    chk_log(b, 14'h200, 4'b0001, 32'h77, "R10");
    chk(par_fault == 2'b01, "R6", "fault flag still set", par_fault, 2'b01);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      r_req[c] = 0; r_wide[c] = 0; r_burst[c] = 0; r_end[c] = 0; r_sub[c] = '0; r_data[c] = '0;
    end
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1 rst_n = 1;
    t_narrow();
    t_wide();
    t_burst();
    t_burst_end();
    t_parity();
    t_refused();
    t_arb();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule